// File: doc/BRIEF.md
# Strap Latch and Frequency Code Selector

This block sits between a clock synthesizer's shared configuration pins and its control logic. While power-on reset (`por_n` low) is asserted, the shared pins are inputs: their output enables are held off and their levels are sampled. When reset ends, the block keeps the sampled levels in a 4-bit frequency strap latch and a 1-bit mode strap latch, then enables the pins as clock outputs.

A control byte, written through a simple load port, sets the rest of the synthesizer's global behaviour. One bit of the byte picks where the active 4-bit frequency code comes from: the latched straps or a register field spread over non-adjacent bits of the byte. Other bits drive spread-spectrum enable, spread depth and a global output tristate. The latched straps are also presented in inverted form for status read-back. The latched mode strap tells the rest of the chip whether the shared stop pin works in desktop or mobile form.

Top module: `strap_freq_ctrl`

## Requirements
- R1: While `por_n` is low, every bit of `pin_oe_o` is 0. At the first rising clock edge that samples `por_n` high, every bit becomes 1.
- R2: At that same edge, the levels on `strap_pin_i` and `mode_pin_i` are captured. Pin changes after that edge have no effect on any output until the next power-on reset.
- R3: `strap_rb_o` equals the bitwise inverse of the captured frequency straps.
- R4: `desktop_mode_o` equals the captured mode strap (1 = desktop, 0 = mobile).
- R5: After power-on reset, the control byte holds its default 8'h82. This gives spread enabled, ±0.5% depth, no tristate and strap-sourced frequency code.
- R6: A write (`cfg_wr_en_i` high at a rising edge) loads `cfg_wr_data_i`, and the outputs show the new byte one cycle later. Without a write, the byte does not change.
- R7: With control bit 3 = 0, `freq_code_o` equals the captured frequency straps.
- R8: With control bit 3 = 1, `freq_code_o` = {bit 2, bit 6, bit 5, bit 4} of the control byte (bit 2 is the MSB).
- R9: `spread_en_o` follows control bit 1. `spread_wide_o` follows control bit 7: 1 selects ±0.5% and 0 selects ±0.25%.
- R10: `tristate_o` follows control bit 0 (1 = all outputs high-impedance).
- R11: Writes presented while `por_n` is low are ignored. The byte leaves reset at its default.
- R12: A later power-on reset pulse captures the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| strap_pin_i | input | 4 | Frequency strap levels seen on the shared pins |
| mode_pin_i | input | 1 | Mode strap level seen on its shared pin |
| cfg_wr_en_i | input | 1 | Control byte load strobe |
| cfg_wr_data_i | input | 8 | Control byte value to load |
| pin_oe_o | output | 5 | Output enables for the shared pins |
| freq_code_o | output | 4 | Active frequency code |
| strap_rb_o | output | 4 | Inverted latched frequency straps |
| desktop_mode_o | output | 1 | Latched mode strap |
| spread_en_o | output | 1 | Spread-spectrum enable |
| spread_wide_o | output | 1 | Spread depth select |
| tristate_o | output | 1 | Global output tristate |

## Verification
Strap capture and the output-enable handover both happen at the first edge that samples `por_n` high. The bench releases reset at a falling edge and checks enables, read-back and code at the next falling edge, one edge later. It then scrambles the pins and rechecks one cycle on. A control write is applied at a falling edge and takes effect at the next rising edge. All decoded outputs are compared at the following falling edge, because the default configuration has no output register. The bench sweeps all 32 strap/mode combinations and all 256 control bytes.

// File: rtl/strap_pkg.sv
package strap_pkg;
   localparam int CODE_W  = 4;
   localparam int CFG_W   = 8;
   localparam int BIT_TRI = 0;
   localparam int BIT_SSE = 1;
   localparam int BIT_SEL = 3;
   localparam int BIT_WID = 7;

   typedef struct packed {
      logic              wide;
      logic              use_reg;
      logic              spread;
      logic              tri_all;
      logic [CODE_W-1:0] reg_code;
   } cfg_fields_t;

   function automatic cfg_fields_t decode_cfg(input logic [CFG_W-1:0] b);
      cfg_fields_t f;
      f.wide     = b[BIT_WID];
      f.use_reg  = b[BIT_SEL];
      f.spread   = b[BIT_SSE];
      f.tri_all  = b[BIT_TRI];
      f.reg_code = {b[2], b[6], b[5], b[4]};
      return f;
   endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
   parameter int CODE_W   = 4,
   parameter int N_SHARED = 5
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [CODE_W-1:0] strap_pin_i,
   input  logic              mode_pin_i,
   output logic [CODE_W-1:0] strap_q_o,
   output logic              mode_q_o,
   output logic              done_o,
   output logic [N_SHARED-1:0] oe_o
);
   logic done_q;

   initial begin
      if (N_SHARED < CODE_W + 1) $error("N_SHARED too small for strap set");
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         done_q    <= 1'b0;
         strap_q_o <= '0;
         mode_q_o  <= 1'b0;
      end else if (!done_q) begin
         done_q    <= 1'b1;
         strap_q_o <= strap_pin_i;
         mode_q_o  <= mode_pin_i;
      end
   end

   for (genvar g = 0; g < N_SHARED; g++) begin : g_oe
      logic oe_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) oe_q <= 1'b0;
         else        oe_q <= 1'b1;
      end
      assign oe_o[g] = oe_q;
   end

   assign done_o = done_q;

   assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
      (done_q && $past(done_q)) |-> ($stable(strap_q_o) && $stable(mode_q_o)));
   assert_oe_after_capture_R1: assert property (@(posedge clk) disable iff (!por_n)
      done_q |-> (&oe_o));
endmodule

// File: rtl/cfg_byte_reg.sv
module cfg_byte_reg #(
   parameter int             CFG_W   = 8,
   parameter logic [CFG_W-1:0] DEFAULT = 8'h82
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             wr_en_i,
   input  logic [CFG_W-1:0] wr_data_i,
   output logic [CFG_W-1:0] q_o
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       q_o <= DEFAULT;
      else if (wr_en_i) q_o <= wr_data_i;
   end

   assert_load_R6: assert property (@(posedge clk) disable iff (!por_n)
      ($past(wr_en_i) && $past(por_n)) |-> (q_o == $past(wr_data_i)));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
      (!$past(wr_en_i) && $past(por_n)) |-> $stable(q_o));
endmodule

// File: rtl/freq_src_mux.sv
module freq_src_mux #(
   parameter int CODE_W  = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              use_reg_i,
   input  logic [CODE_W-1:0] strap_i,
   input  logic [CODE_W-1:0] reg_code_i,
   output logic [CODE_W-1:0] code_o
);
   logic [CODE_W-1:0] pick;
   assign pick = use_reg_i ? reg_code_i : strap_i;

   if (OUT_REG) begin : g_reg
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) code_q <= '0;
         else        code_q <= pick;
      end
      assign code_o = code_q;
   end else begin : g_comb
      assign code_o = pick;
   end
endmodule

// File: rtl/strap_freq_ctrl.sv
module strap_freq_ctrl
   import strap_pkg::*;
#(
   parameter int               N_SHARED    = 5,
   parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'h82,
   parameter bit               CODE_REG    = 1'b0
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic [CODE_W-1:0]   strap_pin_i,
   input  logic                mode_pin_i,
   input  logic                cfg_wr_en_i,
   input  logic [CFG_W-1:0]    cfg_wr_data_i,
   output logic [N_SHARED-1:0] pin_oe_o,
   output logic [CODE_W-1:0]   freq_code_o,
   output logic [CODE_W-1:0]   strap_rb_o,
   output logic                desktop_mode_o,
   output logic                spread_en_o,
   output logic                spread_wide_o,
   output logic                tristate_o
);
   logic [CODE_W-1:0] strap_q;
   logic              mode_q;
   logic              cap_done;
   logic [CFG_W-1:0]  cfg_q;
   cfg_fields_t       cf;

   strap_capture #(.CODE_W(CODE_W), .N_SHARED(N_SHARED)) u_cap (
      .clk(clk), .por_n(por_n), .strap_pin_i(strap_pin_i), .mode_pin_i(mode_pin_i),
      .strap_q_o(strap_q), .mode_q_o(mode_q), .done_o(cap_done), .oe_o(pin_oe_o));

   cfg_byte_reg #(.CFG_W(CFG_W), .DEFAULT(CFG_DEFAULT)) u_cfg (
      .clk(clk), .por_n(por_n), .wr_en_i(cfg_wr_en_i), .wr_data_i(cfg_wr_data_i),
      .q_o(cfg_q));

   assign cf = decode_cfg(cfg_q);

   freq_src_mux #(.CODE_W(CODE_W), .OUT_REG(CODE_REG)) u_mux (
      .clk(clk), .por_n(por_n), .use_reg_i(cf.use_reg), .strap_i(strap_q),
      .reg_code_i(cf.reg_code), .code_o(freq_code_o));

   assign strap_rb_o     = ~strap_q;
   assign desktop_mode_o = mode_q;
   assign spread_en_o    = cf.spread;
   assign spread_wide_o  = cf.wide;
   assign tristate_o     = cf.tri_all;

   if (!CODE_REG) begin : g_chk
      assert_strap_src_R7: assert property (@(posedge clk) disable iff (!por_n)
         (cap_done && !cf.use_reg) |-> (freq_code_o == ~strap_rb_o));
   end
   assert_quiet_R9: assert property (@(posedge clk) disable iff (!por_n)
      (!$past(cfg_wr_en_i) && $past(por_n)) |-> ($stable(spread_en_o) && $stable(spread_wide_o)));
endmodule

// File: tb/strap_freq_ctrl_tb.sv
module strap_freq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [3:0] strap_pin = 4'h0;
   logic       mode_pin = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [4:0] oe;
   logic [3:0] code, rb;
   logic       desk, sse, wide, tri_o;
   int errors = 0, checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   strap_freq_ctrl dut_i (
      .clk(clk), .por_n(por_n), .strap_pin_i(strap_pin), .mode_pin_i(mode_pin),
      .cfg_wr_en_i(wr_en), .cfg_wr_data_i(wr_data), .pin_oe_o(oe),
      .freq_code_o(code), .strap_rb_o(rb), .desktop_mode_o(desk),
      .spread_en_o(sse), .spread_wide_o(wide), .tristate_o(tri_o));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected decoded outputs {code, sse, wide, tri} for a byte and straps
   function automatic logic [6:0] expect_cfg(input logic [7:0] b, input logic [3:0] s);
      logic [3:0] c;
      c = b[3] ? {b[2], b[6], b[5], b[4]} : s;
      return {c, b[1], b[7], b[0]};
   endfunction

   task automatic do_por(input logic [3:0] s, input logic m);
      @(negedge clk);
      por_n = 1'b0; strap_pin = s; mode_pin = m;
      wr_en = 1'b1; wr_data = 8'h79;   // write during reset: must be ignored (R11)
      @(negedge clk);
      chk("R1 oe low in reset", {11'd0, oe}, 16'd0);
      @(negedge clk);
      wr_en = 1'b0;
      por_n = 1'b1;
      @(negedge clk);
      chk("R1 oe high after release", {11'd0, oe}, 16'h1f);
      chk("R3 readback", {12'd0, rb}, {12'd0, ~s});
      chk("R4 mode", {15'd0, desk}, {15'd0, m});
      chk("R5/R11 default outputs", {9'd0, code, sse, wide, tri_o}, {9'd0, expect_cfg(8'h82, s)});
      strap_pin = ~s; mode_pin = ~m;
      @(negedge clk);
      chk("R2 pins ignored after capture", {7'd0, code, rb, desk},
          {7'd0, s, ~s, m});
   endtask

   initial begin
      logic [3:0] last_s;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 32; i++) begin
         do_por(i[3:0], i[4]);       // R12 each pulse recaptures
      end
      last_s = 4'hA;
      do_por(last_s, 1'b1);
      for (int b = 0; b < 256; b++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_data = b[7:0];
         @(negedge clk);
         wr_en = 1'b0;
         chk(b[3] ? "R8 register code" : "R7 strap code", {12'd0, code},
             {12'd0, expect_cfg(b[7:0], last_s)[6:3]});
         chk("R9 spread bits", {14'd0, sse, wide}, {14'd0, b[1], b[7]});
         chk("R10 tristate", {15'd0, tri_o}, {15'd0, b[0]});
         wr_data = ~b[7:0];
         @(negedge clk);
         chk("R6 hold without write", {9'd0, code, sse, wide, tri_o},
             {9'd0, expect_cfg(b[7:0], last_s)});
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule